// File: doc/BRIEF.md
# Edge/Level Interrupt Aggregation Controller

This block merges up to fifteen peripheral request lines into one host interrupt. Each line has its own capture cell. The cell latches a sticky pending flag in one of two ways. In level mode it latches at every clock edge where the request is high. In edge mode it latches only on a rising transition of the request. The flag stays set until software clears it. Software controls per-line enables and a global enable bit, and these decide which pending flags reach the host interrupt output. A separate read-only register shows the live request levels without any latching.

Software uses a small synchronous 32-bit register port that occupies four word offsets from a base address (default 0xB0). The register roles are:

- **Status** (base+0x0): pending flags plus a summary bit.
- **Trigger select** (base+0x4, read): the mode bit of each line.
- **Clear** (base+0x4, write): write-one-to-clear for the pending flags.
- **Enable** (base+0x8): the per-line enables plus the global enable.
- **Live levels** (base+0xC): the current request levels.

Writes to base+0x0 load the trigger-select bits. They cannot collide with the clear function, which owns writes to base+0x4.

Each capture cell is a two-state machine with states `CELL_IDLE` and `CELL_PENDING`. It has three transitions:

- `CELL_IDLE -> CELL_PENDING` when the trigger condition of the line holds.
- `CELL_PENDING -> CELL_IDLE` when a clear bit arrives and the trigger condition does not hold at the same edge.
- `CELL_PENDING -> CELL_PENDING` otherwise.

Top module: `irq_aggregator_top`

## Requirements
- R1: After reset all pending flags, enable bits and trigger-select bits are 0, and `host_irq` is 0.
- R2: With its trigger-select bit at 0 (level mode), a line's pending flag is set at every clock edge where its request is high. The flag remains set after the request falls.
- R3: With its trigger-select bit at 1 (edge mode), a line's pending flag is set at an edge where the request is high and was low at the previous edge. Before the first edge after reset the previous level counts as low. The flag remains set after the request falls.
- R4: Writing a 1 to bit i (0..14) at base+0x4 clears pending flag i, and writing a 0 leaves the flag unchanged. If the trigger condition of line i holds at the same edge, the flag stays 1, so a level-mode line that is still high sets again at once. Bit 15 of a clear write has no effect.
- R5: A read of base+0x0 returns the pending flags in bits 14:0 and their OR in bit 15. Bits 31:16 read as 0.
- R6: A write to base+0x0 loads the trigger-select bits from bits 14:0. A read of base+0x4 returns those bits in 14:0, with all other bits 0.
- R7: Base+0x8 is read/write. Bits 14:0 are the per-line enables and bit 15 is the global enable. Other bits read as 0.
- R8: A read of base+0xC returns the request levels present at the read edge in bits 14:0, with all other bits 0.
- R9: `host_irq` equals global enable AND the OR over i of (pending flag i AND enable i). It reflects register state after each edge with no further delay.
- R10: `reg_rdata` is loaded at the edge where `reg_rd` is high and holds otherwise. Reads of unmapped offsets return 0. A read sees the register values from before a write made at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| src_req | input | 15 | Peripheral request lines |
| host_irq | output | 1 | Aggregated host interrupt |

## Verification
Both capture modes are driven with short pulses, held-high requests and requests that drop after latching. Short pulses show that level and edge capture set at the same edge. Held-high requests show that only level mode re-sets after a clear. Requests that drop after latching confirm that both modes are sticky. Clears are placed on the same edge as a new rising request to show that the set condition overrides the clear. Enable patterns with the global bit on and off separate per-line masking from global gating. A long seeded random run mixes all register accesses with changing requests and compares every read and every cycle of `host_irq` against a bench model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    typedef enum logic {
        CELL_IDLE    = 1'b0,
        CELL_PENDING = 1'b1
    } cell_state_e;

    // word index within the four-register window (addr[3:2])
    localparam logic [1:0] WIX_STATUS = 2'd0;
    localparam logic [1:0] WIX_MODE   = 2'd1;
    localparam logic [1:0] WIX_ENABLE = 2'd2;
    localparam logic [1:0] WIX_LIVE   = 2'd3;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic edge_mode,
    input  logic clr,
    output logic pending
);

    cell_state_e state_q, state_d;
    logic        req_prev_q;
    logic        trig;

    // trigger condition: rising transition in edge mode, level otherwise
    assign trig = edge_mode ? (req & ~req_prev_q) : req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= CELL_IDLE;
            req_prev_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            req_prev_q <= req;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE: begin
                if (trig) state_d = CELL_PENDING;
            end
            CELL_PENDING: begin
                if (clr && !trig) state_d = CELL_IDLE;
            end
            default: state_d = CELL_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == CELL_PENDING);
    end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
    parameter int NUM_SRC = 15
) (
    input  logic [NUM_SRC-1:0] status,
    input  logic [NUM_SRC:0]   enable,
    output logic               summary,
    output logic               irq
);

    localparam int GLB = NUM_SRC;

    logic [NUM_SRC-1:0] masked;

    always_comb begin
        masked  = status & enable[NUM_SRC-1:0];
        summary = |status;
        irq     = enable[GLB] & (|masked);
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_agg_pkg::*;
#(
    parameter int           NUM_SRC = 15,
    parameter int           ADDR_W  = 8,
    parameter int           DATA_W  = 32,
    parameter logic [ADDR_W-1:0] BASE = 'hB0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               rd,
    input  logic [NUM_SRC-1:0] status,
    input  logic               summary,
    input  logic [NUM_SRC-1:0] live,
    output logic [NUM_SRC:0]   enable,
    output logic [NUM_SRC-1:0] mode,
    output logic [NUM_SRC-1:0] clr,
    output logic [DATA_W-1:0]  rdata
);

    localparam int PAD_STATUS = DATA_W - NUM_SRC - 1;
    localparam int PAD_MODE   = DATA_W - NUM_SRC;

    logic              hit;
    logic [1:0]        wix;
    logic [DATA_W-1:0] rd_mux;
    logic [NUM_SRC:0]  enable_q;
    logic [NUM_SRC-1:0] mode_q;
    logic [DATA_W-1:0] rdata_q;

    assign hit = (addr[ADDR_W-1:4] == BASE[ADDR_W-1:4]) && (addr[1:0] == 2'b00);
    assign wix = addr[3:2];

    always_comb begin
        clr = '0;
        if (wr && hit && wix == WIX_MODE) clr = wdata[NUM_SRC-1:0];
    end

    always_comb begin
        rd_mux = '0;
        if (hit) begin
            unique case (wix)
                WIX_STATUS: rd_mux = {{PAD_STATUS{1'b0}}, summary, status};
                WIX_MODE:   rd_mux = {{PAD_MODE{1'b0}}, mode_q};
                WIX_ENABLE: rd_mux = {{PAD_STATUS{1'b0}}, enable_q};
                WIX_LIVE:   rd_mux = {{PAD_MODE{1'b0}}, live};
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
            mode_q   <= '0;
            rdata_q  <= '0;
        end else begin
            if (wr && hit && wix == WIX_ENABLE) enable_q <= wdata[NUM_SRC:0];
            if (wr && hit && wix == WIX_STATUS) mode_q   <= wdata[NUM_SRC-1:0];
            if (rd) rdata_q <= rd_mux;
        end
    end

    assign enable = enable_q;
    assign mode   = mode_q;
    assign rdata  = rdata_q;

endmodule

// File: rtl/irq_aggregator_top.sv
module irq_aggregator_top
    import irq_agg_pkg::*;
#(
    parameter int                NUM_SRC = 15,
    parameter int                ADDR_W  = 8,
    parameter int                DATA_W  = 32,
    parameter logic [ADDR_W-1:0] BASE    = 'hB0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic               reg_rd,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic               host_irq
);

    logic [NUM_SRC-1:0] status_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] mode_vec;
    logic [NUM_SRC:0]   en_vec;
    logic               summary;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_cell
        irq_src_cell u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (src_req[g]),
            .edge_mode (mode_vec[g]),
            .clr       (clr_vec[g]),
            .pending   (status_vec[g])
        );
    end

    irq_regfile #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BASE    (BASE)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (reg_addr),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .rd      (reg_rd),
        .status  (status_vec),
        .summary (summary),
        .live    (src_req),
        .enable  (en_vec),
        .mode    (mode_vec),
        .clr     (clr_vec),
        .rdata   (reg_rdata)
    );

    irq_combiner #(
        .NUM_SRC (NUM_SRC)
    ) u_comb (
        .status  (status_vec),
        .enable  (en_vec),
        .summary (summary),
        .irq     (host_irq)
    );

endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int NUM_SRC = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] req,
    input logic               host_irq,
    input logic [NUM_SRC-1:0] status,
    input logic [NUM_SRC:0]   en,
    input logic [NUM_SRC-1:0] mode,
    input logic [NUM_SRC-1:0] clr
);

    // R1: an edge taken in reset leaves everything cleared
    p_reset_clean_r1: assert property (@(posedge clk)
        !rst_n |=> (status == '0 && en == '0 && mode == '0 && !host_irq));

    // R2 / R3: a pending flag not being cleared stays set
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status & ~clr) & ~status) == '0));

    // R2: a high request on a level-mode line sets its flag
    p_level_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(req & ~mode) & ~status) == '0));

    // R4: cleared level-mode lines with a low request drop
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & $past(clr & ~req & ~mode)) == '0));

    // R9: the host interrupt needs the global enable and a pending flag
    p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> (en[NUM_SRC] && (status != '0)));

endmodule

bind irq_aggregator_top irq_aggregator_chk #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (src_req),
    .host_irq (host_irq),
    .status   (status_vec),
    .en       (en_vec),
    .mode     (mode_vec),
    .clr      (clr_vec)
);

// File: tb/irq_aggregator_top_tb_top.sv
module irq_aggregator_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic [14:0] src_req = '0;
    logic        host_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // bench model state
    logic [14:0] m_st = '0, m_sel = '0, m_prev = '0;
    logic [15:0] m_en = '0;
    logic [31:0] m_rd = '0;

    always #2.5 clk = ~clk;

    irq_aggregator_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .src_req(src_req), .host_irq(host_irq)
    );

    function automatic logic [31:0] model_read(logic [7:0] a, logic [14:0] rq);
        case (a)
            8'hB0:   return {16'b0, |m_st, m_st};
            8'hB4:   return {17'b0, m_sel};
            8'hB8:   return {16'b0, m_en};
            8'hBC:   return {17'b0, rq};
            default: return 32'b0;
        endcase
    endfunction

    function automatic logic [14:0] model_next(logic [14:0] st, logic [14:0] rq,
                                               logic [14:0] pv, logic [14:0] sl,
                                               logic [14:0] cl);
        return (st & ~cl) | (rq & ~sl) | (rq & ~pv & sl);
    endfunction

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // one clock: drive at negedge, update model, check at the next negedge
    task automatic cycle(logic [14:0] rq, logic w, logic [7:0] a, logic [31:0] d,
                         logic r, string tag);
        logic [14:0] cl;
        src_req = rq; reg_wr = w; reg_addr = a; reg_wdata = d; reg_rd = r;
        if (r) m_rd = model_read(a, rq);
        cl = (w && a == 8'hB4) ? d[14:0] : 15'b0;
        m_st = model_next(m_st, rq, m_prev, m_sel, cl);
        m_prev = rq;
        if (w && a == 8'hB0) m_sel = d[14:0];
        if (w && a == 8'hB8) m_en = d[15:0];
        @(posedge clk);
        @(negedge clk);
        check(tag, "host_irq R9", {31'b0, host_irq},
              {31'b0, m_en[15] & (|(m_st & m_en[14:0]))});
        check(tag, "rdata R10", reg_rdata, m_rd);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic idle(logic [14:0] rq, string tag);
        cycle(rq, 1'b0, 8'h00, 32'h0, 1'b0, tag);
    endtask

    task automatic rd(logic [14:0] rq, logic [7:0] a, string tag);
        cycle(rq, 1'b0, a, 32'h0, 1'b1, tag);
    endtask

    task automatic wr(logic [14:0] rq, logic [7:0] a, logic [31:0] d, string tag);
        cycle(rq, 1'b1, a, d, 1'b0, tag);
    endtask

    initial begin
        #(5ns * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state seen through outputs and register reads
        check("R1", "host_irq", {31'b0, host_irq}, 32'h0);
        rst_n = 1'b1;
        rd(15'h0, 8'hB0, "R1");
        rd(15'h0, 8'hB4, "R1");
        rd(15'h0, 8'hB8, "R1");
        check("R1", "status zero", reg_rdata, 32'h0);

        // R7 enable everything
        wr(15'h0, 8'hB8, 32'hFFFF_FFFF, "R7");
        rd(15'h0, 8'hB8, "R7");
        check("R7", "enable value", reg_rdata, 32'h0000_FFFF);

        // R2 level pulse on line 6 stays set after drop; R5 summary
        idle(15'h0040, "R2");
        idle(15'h0, "R2");
        rd(15'h0, 8'hB0, "R5");
        check("R5", "status bits", reg_rdata, 32'h0000_8040);

        // R4 clear with request low, then clear while still high re-sets
        wr(15'h0, 8'hB4, 32'h0000_8040, "R4");
        rd(15'h0, 8'hB0, "R4");
        check("R4", "cleared", reg_rdata, 32'h0);
        idle(15'h0040, "R4");
        wr(15'h0040, 8'hB4, 32'h0000_0040, "R4");
        rd(15'h0040, 8'hB0, "R4");
        check("R4", "level re-set", reg_rdata, 32'h0000_8040);
        wr(15'h0, 8'hB4, 32'h0000_0040, "R4");

        // R6 edge mode on line 12
        wr(15'h0, 8'hB0, 32'hFFFF_1000, "R6");
        rd(15'h0, 8'hB4, "R6");
        check("R6", "select readback", reg_rdata, 32'h0000_1000);
        idle(15'h1000, "R3");
        wr(15'h1000, 8'hB4, 32'h0000_1000, "R3");
        rd(15'h1000, 8'hB0, "R3");
        check("R3", "edge no re-set while high", reg_rdata, 32'h0);
        idle(15'h0, "R3");
        wr(15'h1000, 8'hB4, 32'h0000_1000, "R3");
        rd(15'h0, 8'hB0, "R3");
        check("R3", "edge wins over clear, sticky", reg_rdata, 32'h0000_9000);

        // R9 global enable off masks the interrupt
        wr(15'h0, 8'hB8, 32'h0000_7FFF, "R9");
        check("R9", "gated", {31'b0, host_irq}, 32'h0);
        wr(15'h0, 8'hB8, 32'h0000_8FFF, "R9");
        check("R9", "line masked", {31'b0, host_irq}, 32'h0);

        // R8 live levels, R10 unmapped offsets
        rd(15'h2A55, 8'hBC, "R8");
        check("R8", "live", reg_rdata, 32'h0000_2A55);
        rd(15'h0, 8'h40, "R10");
        check("R10", "unmapped", reg_rdata, 32'h0);
        rd(15'h0, 8'hB2, "R10");

        // constrained random mix
        begin
            logic [14:0] rq;
            rq = '0;
            for (int n = 0; n < 4000; n++) begin
                int op;
                logic [7:0] a;
                if ($urandom_range(0, 3) == 0) rq = rq ^ 15'($urandom);
                op = $urandom_range(0, 9);
                a  = 8'hB0 + 8'(4 * $urandom_range(0, 3));
                if (op < 2)      wr(rq, a, $urandom, "R4");
                else if (op < 5) rd(rq, a, "R2");
                else             idle(rq, "R3");
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule